// File: doc/BRIEF.md
# Output Shift Register with Automatic Refill

This block is the output side of a programmable serial engine. It holds a 32-bit shift register that feeds a destination with words of 1 to 32 bits, taken from either end of the register as the configured direction selects. The register is refilled from a four-entry transmit queue. Refills come from explicit pull operations, or automatically when the number of bits already shifted out has reached a programmable threshold. A separate load operation writes a full word straight into the register. A one-bit "register still holds data" flag is exported for branch decisions.

One operation is presented per cycle on `op_valid`/`op_kind`. The controller decides on a single action for it in the same cycle. That action is one of idle, plain shift, refill-then-shift, pull from queue, pull from the X value, direct load, skip, or stall. The action is held as an enumerated state. A stalled operation must be held by the caller until `op_done` rises. The result word and `op_done` are combinational in the cycle of the operation. The register, the shift counter and the queue change at the following clock edge.

Top module: `osr_unit`

## Requirements
- R1: A bit-count field of 0 means 32 bits. Each completed shift adds its bit count to the shift counter, which saturates at 32.
- R2: With `cfg_shift_right`=1 the result holds the low n bits of the register and the register shifts right by n. With it 0 the result holds the high n bits of the register, placed in bits n-1..0, and the register shifts left by n. All result bits above n-1 are zero.
- R3: With autopull on, a shift issued while the counter is at or above the threshold takes its data from the queue head word and pops it. The counter then equals the bit count.
- R4: With autopull on, such a shift on an empty queue stalls: `op_stall`=1 and `op_done`=0, and the register and counter hold. It completes in the first cycle in which the queue holds a word.
- R5: A pull (`op_kind`=2) on an empty queue stalls when `pull_block`=1. When `pull_block`=0 it loads `x_value` and clears the counter.
- R6: A pull with `pull_if_empty`=1 does nothing unless the counter is at or above the threshold.
- R7: While autopull is on, a pull with the counter at 0 does nothing: the register is unchanged and the queue is not popped.
- R8: `osr_not_empty` is 1 exactly while the counter is below the threshold. A threshold field of 0 means 32.
- R9: A load (`op_kind`=3) writes `mov_value` into the register and clears the counter to 0.
- R10: After reset the counter is 32 (empty), the queue is empty, `tx_full`=0 and `osr_not_empty`=0.
- R11: The queue holds 4 words in arrival order. `tx_full` rises after the fourth push, and a push while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_push | input | 1 | Write one word into the queue |
| tx_data | input | 32 | Word to queue |
| tx_full | output | 1 | Queue holds 4 words |
| cfg_shift_right | input | 1 | 1: shift toward LSB, 0: toward MSB |
| cfg_autopull | input | 1 | Enable automatic refill on shift |
| cfg_pull_thresh | input | 5 | Pull threshold in bits, 0 means 32 |
| op_valid | input | 1 | Operation present |
| op_kind | input | 2 | 0 none, 1 shift, 2 pull, 3 load |
| op_bits | input | 5 | Shift bit count, 0 means 32 |
| pull_if_empty | input | 1 | Pull only when the counter has reached the threshold |
| pull_block | input | 1 | Stall a pull on an empty queue |
| x_value | input | 32 | Scratch X word for non-blocking pull |
| mov_value | input | 32 | Word for the load operation |
| op_done | output | 1 | Operation completes this cycle |
| op_stall | output | 1 | Operation must be held |
| out_word | output | 32 | Zero-extended shift result |
| osr_not_empty | output | 1 | Counter below threshold |

## Verification
`op_done`, `op_stall` and `out_word` depend only on inputs and current state, so the bench drives each operation on the falling edge and samples these outputs 1 ns later, in the same cycle. Register, counter and queue effects are due one rising edge later. The bench reads them 1 ns after that edge, through `osr_not_empty` or through a following shift that exposes the register contents. A queue push appears at the head one edge after it is driven, so a stalled refill is expected to complete in the cycle after the push edge and not before.

// File: rtl/osr_pkg.sv
package osr_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_PULL  = 2'd2,
        OP_LOAD  = 2'd3
    } op_kind_t;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_SHIFT,
        ACT_REFILL_SHIFT,
        ACT_PULL_FIFO,
        ACT_PULL_X,
        ACT_LOAD,
        ACT_SKIP,
        ACT_STALL
    } act_t;
endpackage

// File: rtl/osr_txfifo.sv
module osr_txfifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         full,
    output logic         empty,
    output logic [W-1:0] head
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [LW-1:0] level;
    logic          do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign head    = mem[rd_ptr];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            level <= level + LW'(do_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    p_pop_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    p_drop_when_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> full);
endmodule

// File: rtl/osr_shift.sv
module osr_shift #(
    parameter int W = 32
) (
    input  logic [W-1:0]           src,
    input  logic [$clog2(W):0]     nbits,
    input  logic                   to_right,
    output logic [W-1:0]           word,
    output logic [W-1:0]           rest
);
    localparam int CW = $clog2(W) + 1;

    logic [CW-1:0] gap;
    logic [W-1:0]  low_mask;

    always_comb begin
        gap      = CW'(W) - nbits;
        low_mask = {W{1'b1}} >> gap;
        if (to_right) begin
            word = src & low_mask;
            rest = src >> nbits;
        end else begin
            word = src >> gap;
            rest = src << nbits;
        end
    end
endmodule

// File: rtl/osr_ctrl.sv
module osr_ctrl
    import osr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_shift_right,
    input  logic                 cfg_autopull,
    input  logic [$clog2(W)-1:0] cfg_pull_thresh,
    input  logic                 op_valid,
    input  logic [1:0]           op_kind,
    input  logic [$clog2(W)-1:0] op_bits,
    input  logic                 pull_if_empty,
    input  logic                 pull_block,
    input  logic [W-1:0]         x_value,
    input  logic [W-1:0]         mov_value,
    input  logic                 fifo_empty,
    input  logic [W-1:0]         fifo_head,
    output logic                 fifo_pop,
    output logic [W-1:0]         sh_src,
    output logic [$clog2(W):0]   sh_n,
    input  logic [W-1:0]         sh_word,
    input  logic [W-1:0]         sh_rest,
    output logic                 op_done,
    output logic                 op_stall,
    output logic [W-1:0]         out_word,
    output logic                 osr_not_empty
);
    localparam int CW = $clog2(W) + 1;

    logic [W-1:0]  osr_q, osr_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] thr;
    logic [CW:0]   cnt_sum;
    logic          drained;
    act_t          act;

    assign thr     = (cfg_pull_thresh == '0) ? CW'(W) : {1'b0, cfg_pull_thresh};
    assign sh_n    = (op_bits == '0) ? CW'(W) : {1'b0, op_bits};
    assign drained = (cnt_q >= thr);
    assign osr_not_empty = !drained;

    // action decision: one enumerated state per operation cycle
    always_comb begin
        act = ACT_IDLE;
        if (op_valid) begin
            unique case (op_kind_t'(op_kind))
                OP_SHIFT: begin
                    if (cfg_autopull && drained)
                        act = fifo_empty ? ACT_STALL : ACT_REFILL_SHIFT;
                    else
                        act = ACT_SHIFT;
                end
                OP_PULL: begin
                    if (cfg_autopull && cnt_q == '0)   act = ACT_SKIP;
                    else if (pull_if_empty && !drained) act = ACT_SKIP;
                    else if (!fifo_empty)               act = ACT_PULL_FIFO;
                    else if (pull_block)                act = ACT_STALL;
                    else                                act = ACT_PULL_X;
                end
                OP_LOAD: act = ACT_LOAD;
                OP_NONE: act = ACT_IDLE;
            endcase
        end
    end

    // outputs and next state
    always_comb begin
        sh_src   = (act == ACT_REFILL_SHIFT) ? fifo_head : osr_q;
        fifo_pop = (act == ACT_REFILL_SHIFT) || (act == ACT_PULL_FIFO);
        op_stall = (act == ACT_STALL);
        op_done  = op_valid && (act != ACT_STALL);
        out_word = '0;
        cnt_sum  = {1'b0, cnt_q} + {1'b0, sh_n};
        osr_d    = osr_q;
        cnt_d    = cnt_q;
        unique case (act)
            ACT_SHIFT: begin
                out_word = sh_word;
                osr_d    = sh_rest;
                cnt_d    = (cnt_sum > (CW + 1)'(W)) ? CW'(W) : cnt_sum[CW-1:0];
            end
            ACT_REFILL_SHIFT: begin
                out_word = sh_word;
                osr_d    = sh_rest;
                cnt_d    = sh_n;
            end
            ACT_PULL_FIFO: begin
                osr_d = fifo_head;
                cnt_d = '0;
            end
            ACT_PULL_X: begin
                osr_d = x_value;
                cnt_d = '0;
            end
            ACT_LOAD: begin
                osr_d = mov_value;
                cnt_d = '0;
            end
            ACT_IDLE, ACT_SKIP, ACT_STALL: begin
                osr_d = osr_q;
                cnt_d = cnt_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osr_q <= '0;
            cnt_q <= CW'(W);
        end else begin
            osr_q <= osr_d;
            cnt_q <= cnt_d;
        end
    end

    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(W));
    p_stall_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_stall |=> ($stable(osr_q) && $stable(cnt_q)));
    p_load_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && op_kind == 2'd3) |=> (osr_not_empty && cnt_q == '0));
    p_skip_no_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_autopull && op_valid && op_kind == 2'd2 && cnt_q == '0) |-> !fifo_pop);
    p_zero_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && op_kind == 2'd1 && sh_n < CW'(W)) |-> ((out_word >> sh_n) == '0));
endmodule

// File: rtl/osr_unit.sv
module osr_unit #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_push,
    input  logic [W-1:0]         tx_data,
    output logic                 tx_full,
    input  logic                 cfg_shift_right,
    input  logic                 cfg_autopull,
    input  logic [$clog2(W)-1:0] cfg_pull_thresh,
    input  logic                 op_valid,
    input  logic [1:0]           op_kind,
    input  logic [$clog2(W)-1:0] op_bits,
    input  logic                 pull_if_empty,
    input  logic                 pull_block,
    input  logic [W-1:0]         x_value,
    input  logic [W-1:0]         mov_value,
    output logic                 op_done,
    output logic                 op_stall,
    output logic [W-1:0]         out_word,
    output logic                 osr_not_empty
);
    localparam int CW = $clog2(W) + 1;

    logic          f_pop, f_empty;
    logic [W-1:0]  f_head;
    logic [W-1:0]  s_src, s_word, s_rest;
    logic [CW-1:0] s_n;

    osr_txfifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .push_data(tx_data), .pop(f_pop),
        .full(tx_full), .empty(f_empty), .head(f_head)
    );

    osr_shift #(.W(W)) u_shift (
        .src(s_src), .nbits(s_n), .to_right(cfg_shift_right),
        .word(s_word), .rest(s_rest)
    );

    osr_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_shift_right(cfg_shift_right), .cfg_autopull(cfg_autopull),
        .cfg_pull_thresh(cfg_pull_thresh),
        .op_valid(op_valid), .op_kind(op_kind), .op_bits(op_bits),
        .pull_if_empty(pull_if_empty), .pull_block(pull_block),
        .x_value(x_value), .mov_value(mov_value),
        .fifo_empty(f_empty), .fifo_head(f_head), .fifo_pop(f_pop),
        .sh_src(s_src), .sh_n(s_n), .sh_word(s_word), .sh_rest(s_rest),
        .op_done(op_done), .op_stall(op_stall), .out_word(out_word),
        .osr_not_empty(osr_not_empty)
    );
endmodule

// File: tb/osr_unit_tb.sv
module osr_unit_tb;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tx_push;
    logic [31:0] tx_data;
    logic        tx_full;
    logic        cfg_shift_right, cfg_autopull;
    logic [4:0]  cfg_pull_thresh;
    logic        op_valid;
    logic [1:0]  op_kind;
    logic [4:0]  op_bits;
    logic        pull_if_empty, pull_block;
    logic [31:0] x_value, mov_value;
    logic        op_done, op_stall, osr_not_empty;
    logic [31:0] out_word;

    int n_checks = 0;
    int n_fail   = 0;
    logic        r_done, r_stall;
    logic [31:0] r_word;

    always #(PERIOD / 2) clk = ~clk;

    osr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
        .cfg_shift_right(cfg_shift_right), .cfg_autopull(cfg_autopull),
        .cfg_pull_thresh(cfg_pull_thresh), .op_valid(op_valid), .op_kind(op_kind),
        .op_bits(op_bits), .pull_if_empty(pull_if_empty), .pull_block(pull_block),
        .x_value(x_value), .mov_value(mov_value), .op_done(op_done), .op_stall(op_stall),
        .out_word(out_word), .osr_not_empty(osr_not_empty)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reset_dut();
        rst_n = 1'b0; tx_push = 0; tx_data = 0; op_valid = 0; op_kind = 0; op_bits = 0;
        pull_if_empty = 0; pull_block = 0; x_value = 0; mov_value = 0;
        cfg_shift_right = 1; cfg_autopull = 0; cfg_pull_thresh = 0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push(input logic [31:0] d);
        @(negedge clk); tx_push = 1; tx_data = d;
        @(posedge clk); #1 tx_push = 0;
    endtask

    task automatic run_op(input logic [1:0] k, input logic [4:0] b, input bit ife, input bit blk);
        @(negedge clk);
        op_valid = 1; op_kind = k; op_bits = b; pull_if_empty = ife; pull_block = blk;
        #1 r_done = op_done; r_stall = op_stall; r_word = out_word;
        @(posedge clk); #1 op_valid = 0;
    endtask

    task automatic t_reset();
        reset_dut();
        chk(osr_not_empty == 0, "R10 not_empty after reset", 32'(osr_not_empty), 0);
        chk(tx_full == 0, "R10 tx_full after reset", 32'(tx_full), 0);
        chk(op_done == 0, "R10 no op done", 32'(op_done), 0);
    endtask

    task automatic t_right();
        reset_dut();
        mov_value = 32'hDEADBEEF;
        run_op(2'd3, 0, 0, 0);
        chk(osr_not_empty == 1, "R9 load fills register", 32'(osr_not_empty), 1);
        run_op(2'd1, 5'd8, 0, 0);
        chk(r_done && r_word == 32'hEF, "R2 right shift 8", r_word, 32'hEF);
        run_op(2'd1, 5'd0, 0, 0);
        chk(r_word == 32'h00DEADBE, "R1 count 0 means 32", r_word, 32'h00DEADBE);
        chk(osr_not_empty == 0, "R1 counter saturates at 32", 32'(osr_not_empty), 0);
        run_op(2'd1, 5'd4, 0, 0);
        chk(r_done && r_word == 0, "R1 shift without autopull continues", r_word, 0);
    endtask

    task automatic t_left();
        reset_dut();
        cfg_shift_right = 0; mov_value = 32'h12345678;
        run_op(2'd3, 0, 0, 0);
        run_op(2'd1, 5'd4, 0, 0);
        chk(r_word == 32'h1, "R2 left shift 4", r_word, 32'h1);
        run_op(2'd1, 5'd8, 0, 0);
        chk(r_word == 32'h23, "R2 left shift 8", r_word, 32'h23);
    endtask

    task automatic t_thresh();
        reset_dut();
        cfg_pull_thresh = 5'd8; mov_value = 32'hFFFF0000;
        run_op(2'd3, 0, 0, 0);
        run_op(2'd1, 5'd4, 0, 0);
        chk(osr_not_empty == 1, "R8 below threshold", 32'(osr_not_empty), 1);
        run_op(2'd1, 5'd4, 0, 0);
        chk(osr_not_empty == 0, "R8 at threshold 8", 32'(osr_not_empty), 0);
        @(negedge clk); cfg_pull_thresh = 0; #1;
        chk(osr_not_empty == 1, "R8 threshold 0 means 32", 32'(osr_not_empty), 1);
    endtask

    task automatic t_autopull();
        reset_dut();
        cfg_autopull = 1;
        push(32'hA5A50F0F);
        run_op(2'd1, 5'd16, 0, 0);
        chk(r_done && r_word == 32'h0F0F, "R3 autopull on first shift", r_word, 32'h0F0F);
        run_op(2'd1, 5'd16, 0, 0);
        chk(r_word == 32'hA5A5, "R3 second half", r_word, 32'hA5A5);
        @(negedge clk);
        op_valid = 1; op_kind = 2'd1; op_bits = 5'd8;
        #1 chk(op_stall && !op_done, "R4 stall on empty queue", {op_stall, op_done}, 32'h2);
        @(negedge clk);
        tx_push = 1; tx_data = 32'h11223344;
        #1 chk(op_stall == 1, "R4 still stalled before push lands", 32'(op_stall), 1);
        @(posedge clk); #1 tx_push = 0;
        @(negedge clk); #1;
        chk(op_done && out_word == 32'h44, "R4 completes after push", out_word, 32'h44);
        @(posedge clk); #1 op_valid = 0;
        chk(osr_not_empty == 1, "R3 counter equals bit count", 32'(osr_not_empty), 1);
        // R7: pull while full is ignored under autopull
        mov_value = 32'h55AA55AA;
        run_op(2'd3, 0, 0, 0);
        push(32'h77777777);
        run_op(2'd2, 0, 0, 1);
        chk(r_done == 1, "R7 pull completes as no-op", 32'(r_done), 1);
        run_op(2'd1, 5'd0, 0, 0);
        chk(r_word == 32'h55AA55AA, "R7 register unchanged by pull", r_word, 32'h55AA55AA);
        run_op(2'd1, 5'd8, 0, 0);
        chk(r_word == 32'h77, "R7 queue not popped", r_word, 32'h77);
    endtask

    task automatic t_pull();
        reset_dut();
        mov_value = 32'h0BADF00D;
        run_op(2'd3, 0, 0, 0);
        push(32'h600DCAFE);
        run_op(2'd2, 0, 1, 0);
        run_op(2'd1, 5'd0, 0, 0);
        chk(r_word == 32'h0BADF00D, "R6 if-empty pull skipped", r_word, 32'h0BADF00D);
        run_op(2'd2, 0, 1, 0);
        run_op(2'd1, 5'd0, 0, 0);
        chk(r_word == 32'h600DCAFE, "R6 if-empty pull loads when drained", r_word, 32'h600DCAFE);
        x_value = 32'hCAFE1234;
        run_op(2'd2, 0, 0, 0);
        chk(r_done == 1, "R5 nonblocking pull done", 32'(r_done), 1);
        run_op(2'd1, 5'd0, 0, 0);
        chk(r_word == 32'hCAFE1234, "R5 nonblocking pull takes X", r_word, 32'hCAFE1234);
        run_op(2'd2, 0, 0, 1);
        chk(r_stall && !r_done, "R5 blocking pull stalls", {r_stall, r_done}, 32'h2);
    endtask

    task automatic t_fifo();
        reset_dut();
        for (int i = 0; i < 4; i++) push(32'h1000 + i);
        chk(tx_full == 1, "R11 full after 4 pushes", 32'(tx_full), 1);
        push(32'hBAD0BAD0);
        x_value = 32'h0000FACE;
        for (int i = 0; i < 4; i++) begin
            run_op(2'd2, 0, 0, 0);
            run_op(2'd1, 5'd0, 0, 0);
            chk(r_word == 32'h1000 + i, "R11 arrival order", r_word, 32'h1000 + i);
        end
        run_op(2'd2, 0, 0, 0);
        run_op(2'd1, 5'd0, 0, 0);
        chk(r_word == 32'h0000FACE, "R11 push while full dropped", r_word, 32'h0000FACE);
    endtask

    bit finished = 0;

    initial begin
        t_reset();
        t_right();
        t_left();
        t_thresh();
        t_autopull();
        t_pull();
        t_fifo();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule